// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a single-cycle integer arithmetic and logic unit with a small registered status word beside it. Each cycle it takes two operands and an operation code and drives a result together with a freshly computed set of six status bits: carry, overflow, sign, zero, nibble carry and low-byte parity. The result and the fresh status bits are combinational. The status word is a register: it captures the fresh bits on a clock edge when the load enable is high, and it keeps its value otherwise.

Two of the additions (add-with-carry and subtract-with-borrow) feed the registered carry bit back in as their carry or borrow, so long multi-word sums and differences can be chained across cycles. A compare produces the same status as a subtraction but marks its result as not to be written back. Software-style direct access is provided through a separate path that forces one chosen status bit to 0 or 1 without touching the others.

Top module: `int_alu_flags`

## Requirements
- R1: Codes 0 (add) and 1 (add-with-carry) give result = a + b (+ registered carry for code 1) modulo 2^W; carry (status bit 0) is the carry out of the top bit.
- R2: Codes 2 (subtract), 3 (subtract-with-borrow) and 7 (compare) give result = a - b (- registered carry for code 3) modulo 2^W; carry (bit 0) is set exactly when the unsigned subtraction needed a borrow.
- R3: Overflow (bit 5) is set exactly when the arithmetic result, read as two's complement, is outside the signed range of W bits.
- R4: Sign (bit 4) equals the top bit of the result, and zero (bit 3) is set exactly when all W result bits are 0.
- R5: Nibble carry (bit 2) is the carry from bit 3 into bit 4 for additions, and the borrow out of the low four bits for subtractions and compare.
- R6: Parity (bit 1) is set when the low eight bits of the result hold an even number of ones; the upper bits have no effect on it.
- R7: Codes 4 (AND), 5 (OR) and 6 (XOR) give the bitwise result and clear carry, overflow and nibble carry.
- R8: The write-back valid output equals the valid input for every code except compare (7), for which it is 0.
- R9: The status register is 0 after reset, loads all six fresh bits on a clock edge when the load enable is high and the direct path idle, and holds otherwise.
- R10: When the direct path is requested, only the status bit at the selected index (0 to 5) takes the given value on the edge; the load enable is ignored, and an index of 6 or 7 leaves the whole register unchanged.
- R11: Add-with-carry and subtract-with-borrow use the registered carry bit, not the fresh one, as their carry or borrow input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| flag_we_i | input | 1 | Load fresh status bits into the register |
| flag_mod_i | input | 1 | Direct write of one status bit |
| flag_sel_i | input | 3 | Index of the status bit for a direct write |
| flag_val_i | input | 1 | Value for a direct write |
| result_o | output | W | Operation result |
| res_valid_o | output | 1 | Result is to be written back |
| next_flags_o | output | 6 | Fresh status bits of this operation |
| flags_o | output | 6 | Registered status bits |

## Verification
The hardest case to reach is a chained subtract-with-borrow whose operands are equal while the registered carry is set, which must wrap to all ones with borrow, sign and nibble borrow set; it needs the register prepared by an earlier borrowing subtraction or by the direct write path. The bench builds such chains on purpose, sets and clears the carry directly between them, and then runs a long random mix in which the load enable and direct writes vary every cycle so that the carried-in value keeps changing.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_CMP = 3'd7
  } alu_op_e;

  localparam int NFLAG = 6;
  localparam int FL_C = 0;
  localparam int FL_P = 1;
  localparam int FL_A = 2;
  localparam int FL_Z = 3;
  localparam int FL_S = 4;
  localparam int FL_V = 5;

  function automatic logic even_ones8(input logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic is_subtract(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  endfunction

  function automatic logic is_bitwise(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction
endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
module alu_arith #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry_flag,
  output logic         aux_flag,
  output logic         ovf_flag
);
  logic [W-1:0] b_eff;
  logic         c0;
  logic [4:0]   low_sum;
  logic [W:0]   full_sum;

  assign b_eff    = sub ? ~b : b;
  assign c0       = sub ? ~cin : cin;
  assign low_sum  = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0, c0};
  assign full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};

  assign sum        = full_sum[W-1:0];
  assign carry_flag = sub ? ~full_sum[W] : full_sum[W];
  assign aux_flag   = sub ? ~low_sum[4] : low_sum[4];
  assign ovf_flag   = (a[W-1] == b_eff[W-1]) && (full_sum[W-1] != a[W-1]);

  // R2
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && !cin) |-> (carry_flag == (a < b)));

  // R2
  sub_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && !cin) |-> ((sum == '0) == (a == b)));

  // R1
  add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub && !cin && b == '0) |-> (sum == a && !carry_flag && !ovf_flag && !aux_flag));
endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise #(
  parameter int W = 32
) (
  input  alu_pkg::alu_op_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     res
);
  import alu_pkg::*;
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_flagreg.sv
`timescale 1ns/1ps
module alu_flagreg #(
  parameter int NF   = 6,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            mod,
  input  logic [SELW-1:0] sel,
  input  logic            val,
  input  logic [NF-1:0]   fresh,
  output logic [NF-1:0]   flags
);
  logic sel_ok;
  assign sel_ok = (int'(sel) < NF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (mod) begin
      if (sel_ok) flags[sel] <= val;
    end else if (we) begin
      flags <= fresh;
    end
  end

  // R9
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !mod) |=> (flags == $past(fresh)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !mod) |=> $stable(flags));

  // R10
  flag_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod && sel_ok) |=> (flags[$past(sel)] == $past(val)));

  // R10
  flag_badsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod && !sel_ok) |=> $stable(flags));

  // R10
  flag_onebit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod |=> ($countones(flags ^ $past(flags)) <= 1));
endmodule

// File: rtl/int_alu_flags.sv
`timescale 1ns/1ps
module int_alu_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         flag_we_i,
  input  logic         flag_mod_i,
  input  logic [2:0]   flag_sel_i,
  input  logic         flag_val_i,
  output logic [W-1:0] result_o,
  output logic         res_valid_o,
  output logic [5:0]   next_flags_o,
  output logic [5:0]   flags_o
);
  import alu_pkg::*;

  alu_op_e      op;
  logic         do_sub;
  logic         do_bitwise;
  logic         carry_in;
  logic [W-1:0] arith_sum;
  logic [W-1:0] bit_res;
  logic         ar_carry;
  logic         ar_aux;
  logic         ar_ovf;
  logic [W-1:0] result;
  logic [NFLAG-1:0] fresh;

  assign op         = alu_op_e'(op_i);
  assign do_sub     = is_subtract(op);
  assign do_bitwise = is_bitwise(op);
  assign carry_in   = ((op == OP_ADC) || (op == OP_SBB)) ? flags_o[FL_C] : 1'b0;

  alu_arith #(.W(W)) u_arith (
    .clk(clk), .rst_n(rst_n), .a(a_i), .b(b_i), .sub(do_sub), .cin(carry_in),
    .sum(arith_sum), .carry_flag(ar_carry), .aux_flag(ar_aux), .ovf_flag(ar_ovf)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .op(op), .a(a_i), .b(b_i), .res(bit_res)
  );

  assign result = do_bitwise ? bit_res : arith_sum;

  always_comb begin
    fresh       = '0;
    fresh[FL_C] = do_bitwise ? 1'b0 : ar_carry;
    fresh[FL_V] = do_bitwise ? 1'b0 : ar_ovf;
    fresh[FL_A] = do_bitwise ? 1'b0 : ar_aux;
    fresh[FL_S] = result[W-1];
    fresh[FL_Z] = (result == '0);
    fresh[FL_P] = even_ones8(result[7:0]);
  end

  alu_flagreg #(.NF(NFLAG), .SELW(3)) u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we_i), .mod(flag_mod_i),
    .sel(flag_sel_i), .val(flag_val_i), .fresh(fresh), .flags(flags_o)
  );

  assign result_o     = result;
  assign res_valid_o  = valid_i && (op != OP_CMP);
  assign next_flags_o = fresh;

  // R8
  cmp_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd7) |-> !res_valid_o);

  // R7
  bitwise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4 || op_i == 3'd5 || op_i == 3'd6) |->
      (next_flags_o[0] == 1'b0 && next_flags_o[5] == 1'b0 && next_flags_o[2] == 1'b0));

  // R11
  adc_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1 && flags_o[0] && a_i == '1 && b_i == '0) |->
      (result_o == '0 && next_flags_o[0]));

  // R11
  sbb_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && flags_o[0] && a_i == b_i) |->
      (result_o == '1 && next_flags_o[0]));
endmodule

// File: tb/sim_int_alu_flags.sv
`timescale 1ns/1ps
module sim_int_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] a_i = 32'd0;
  logic [31:0] b_i = 32'd0;
  logic        flag_we_i = 1'b0;
  logic        flag_mod_i = 1'b0;
  logic [2:0]  flag_sel_i = 3'd0;
  logic        flag_val_i = 1'b0;
  logic [31:0] result_o;
  logic        res_valid_o;
  logic [5:0]  next_flags_o;
  logic [5:0]  flags_o;

  int n_tests = 0;
  int n_fail = 0;
  logic [5:0] mflags = 6'd0;
  logic       last_mod = 1'b0;

  always #5 clk = ~clk;

  int_alu_flags #(.W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flag_we_i(flag_we_i), .flag_mod_i(flag_mod_i), .flag_sel_i(flag_sel_i),
    .flag_val_i(flag_val_i), .result_o(result_o), .res_valid_o(res_valid_o),
    .next_flags_o(next_flags_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: integer arithmetic, no gate structure.
  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       input int cin, output logic [31:0] r, output logic [5:0] f);
    longint ua, ub, sa, sb, d, sd;
    int ones;
    ua = a; ub = b; sa = $signed(a); sb = $signed(b);
    f = 6'd0;
    if (op == 0 || op == 1) begin
      d = ua + ub + cin; sd = sa + sb + cin;
      r = d[31:0];
      f[0] = (d > 64'sd4294967295);
      f[2] = ((ua % 16) + (ub % 16) + cin) > 15;
      f[5] = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    end else if (op == 2 || op == 3 || op == 7) begin
      d = ua - ub - cin; sd = sa - sb - cin;
      r = d[31:0];
      f[0] = (d < 0);
      f[2] = (ua % 16) < ((ub % 16) + cin);
      f[5] = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    end else begin
      r = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
    end
    f[4] = r[31];
    f[3] = (r == 32'd0);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    f[1] = (ones % 2 == 0);
  endtask

  task automatic step(input int op, input logic [31:0] a, input logic [31:0] b,
                      input logic we, input logic md, input int sel, input logic val);
    logic [31:0] er;
    logic [5:0]  ef;
    int cin;
    string ct;
    @(negedge clk);
    chk(last_mod ? "R10 flags_o" : "R9 flags_o", {26'd0, flags_o}, {26'd0, mflags});
    valid_i = 1'b1; op_i = op[2:0]; a_i = a; b_i = b;
    flag_we_i = we; flag_mod_i = md; flag_sel_i = sel[2:0]; flag_val_i = val;
    cin = (op == 1 || op == 3) ? int'(mflags[0]) : 0;
    model(op, a, b, cin, er, ef);
    #1;
    if (op == 1 || op == 3) chk("R11 result", result_o, er);
    else if (op >= 4 && op <= 6) chk("R7 result", result_o, er);
    else if (op == 0) chk("R1 result", result_o, er);
    else chk("R2 result", result_o, er);
    ct = (op >= 4 && op <= 6) ? "R7" : (op <= 1) ? "R1" : "R2";
    chk({ct, " carry"}, {31'd0, next_flags_o[0]}, {31'd0, ef[0]});
    chk("R6 parity", {31'd0, next_flags_o[1]}, {31'd0, ef[1]});
    chk((op >= 4 && op <= 6) ? "R7 nibble" : "R5 nibble", {31'd0, next_flags_o[2]}, {31'd0, ef[2]});
    chk("R4 zero", {31'd0, next_flags_o[3]}, {31'd0, ef[3]});
    chk("R4 sign", {31'd0, next_flags_o[4]}, {31'd0, ef[4]});
    chk((op >= 4 && op <= 6) ? "R7 ovf" : "R3 ovf", {31'd0, next_flags_o[5]}, {31'd0, ef[5]});
    chk("R8 res_valid", {31'd0, res_valid_o}, {31'd0, op != 7});
    @(posedge clk);
    if (md) begin
      if (sel < 6) mflags[sel] = val;
    end else if (we) begin
      mflags = ef;
    end
    last_mod = md;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset flags", {26'd0, flags_o}, 32'd0);
    // R1 carry out, zero, nibble carry
    step(0, 32'hFFFF_FFFF, 32'd1, 1, 0, 0, 0);
    // R3 signed overflow on add
    step(0, 32'h7FFF_FFFF, 32'd1, 1, 0, 0, 0);
    // R11 chained add uses registered carry
    step(0, 32'hFFFF_FFFF, 32'd2, 1, 0, 0, 0);
    step(1, 32'hFFFF_FFFF, 32'd0, 1, 0, 0, 0);
    step(1, 32'd5, 32'd6, 1, 0, 0, 0);
    // R2 borrow, R5 nibble borrow
    step(2, 32'd5, 32'd7, 1, 0, 0, 0);
    // R11 subtract with borrow, equal operands
    step(3, 32'h1234_5678, 32'h1234_5678, 1, 0, 0, 0);
    step(3, 32'd9, 32'd3, 1, 0, 0, 0);
    // R3 overflow on subtract
    step(2, 32'h8000_0000, 32'd1, 1, 0, 0, 0);
    // R8 compare equal, result not written back
    step(7, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1, 0, 0, 0);
    step(7, 32'd1, 32'd2, 1, 0, 0, 0);
    // R6 parity only over low byte
    step(4, 32'hFFFF_FF00, 32'hFFFF_FFFF, 1, 0, 0, 0);
    step(5, 32'h0000_0100, 32'h0000_0003, 1, 0, 0, 0);
    step(6, 32'hF0F0_F0F0, 32'hF0F0_F0F1, 1, 0, 0, 0);
    // R7 logic clears carry after a carrying add
    step(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 0);
    step(6, 32'h8000_000F, 32'h0000_0001, 1, 0, 0, 0);
    // R10 direct set/clear, priority over load, bad index ignored
    step(0, 32'd0, 32'd0, 0, 1, 0, 1);
    step(1, 32'd0, 32'd0, 1, 1, 5, 1);
    step(3, 32'd4, 32'd4, 0, 1, 6, 0);
    step(2, 32'd4, 32'd4, 0, 1, 7, 0);
    step(0, 32'd1, 32'd1, 1, 1, 0, 0);
    // R9 hold when load disabled
    step(0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0);
    step(3, 32'd0, 32'd0, 0, 0, 0, 0);
    for (int k = 0; k < 600; k++) begin
      logic [31:0] ra, rb;
      int pick;
      ra = $urandom; rb = $urandom;
      pick = $urandom % 8;
      if (pick == 0) rb = ra;
      else if (pick == 1) ra = 32'hFFFF_FFFF;
      else if (pick == 2) rb = 32'h8000_0000;
      step($urandom % 8, ra, rb, ($urandom % 4) != 0, ($urandom % 8) == 0,
           $urandom % 8, $urandom % 2);
    end
    @(negedge clk);
    chk(last_mod ? "R10 final flags" : "R9 final flags", {26'd0, flags_o}, {26'd0, mflags});
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule